// File: doc/BRIEF.md
# Multi-Phase PWM Generator

This block produces several pulse-width-modulated outputs from a single free-running period counter. Every channel therefore runs at the same frequency. Each channel has its own start offset and its own high-time length. A channel goes high when the shared count reaches its offset and stays high for its duty count. When the offset plus the duty passes the end of the period, the high window continues at the start of the next period. This makes the block suitable for interleaved power stages and multi-phase motor drives, where the channels must stay locked to one another.

Software sets the period and the per-channel settings through a simple write port. Every written value goes first into a staging copy. A staging copy moves into the live settings only when the counter wraps to zero. Because of this, a setting that changes mid-period cannot cut a pulse short or add a glitch pulse. All outputs come from flops that update on the same clock edge.

Top module: `mpwm_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released, every output is low, the counter is at 0, the live period is `DEF_PERIOD`, and every live offset and duty is 0.
- R2: One counter serves all channels. It counts 0, 1, ..., P-1 and then returns to 0, where P is the live period. All channels therefore repeat with the same period P.
- R3: For a count value c, channel k is high when (c - offset_k) mod P < duty_k. A window that runs past P-1 continues at count 0.
- R4: A duty of 0 keeps a channel low for the whole period. A duty of P or more keeps it high for the whole period.
- R5: A write changes only the staging copy. Staged values become live on the clock edge where the counter goes from its last count to 0. A write accepted on that same edge becomes live one period later.
- R6: Write address 0 selects the period. Address 2k+1 selects the offset of channel k, and address 2k+2 selects the duty of channel k. A write to any higher address changes nothing.
- R7: A live offset equal to or greater than the live period acts as an offset of 0.
- R8: A live period of 0 acts as a period of 1. With a period of 1 the counter stays at 0, and a channel is high exactly when its duty is at least 1.
- R9: Each output is registered. The level shown in the cycle after the counter held value c is the level that value c selects, and all channels change on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the staging registers |
| wr_addr | input | AW ($clog2(2*CH+1)) | Staging register select |
| wr_data | input | W | Value to write |
| pwm_o | output | CH | One registered PWM output per channel |

## Verification
The hardest case to reach from the ports is a write that lands while a period is running, including a write on the exact edge where the counter wraps. A write on that edge has to wait a full further period before it takes effect. The bench keeps its own cycle-accurate model of the counter, the staging copies and the live settings, so it always knows the current count. It uses that count to issue writes at chosen counts, including mid-period and on the last count before the wrap. It then compares every output in every cycle against the model.

// File: rtl/mpwm_pkg.sv
// Package: address map helpers shared by the register bank and users.
// Assumes one period register followed by (offset, duty) pairs per channel.
package mpwm_pkg;
    localparam int unsigned PERIOD_ADDR = 0;

    // Address of the offset register of channel ch.
    function automatic int unsigned phase_addr(int unsigned ch);
        return 2 * ch + 1;
    endfunction

    // Address of the duty register of channel ch.
    function automatic int unsigned duty_addr(int unsigned ch);
        return 2 * ch + 2;
    endfunction
endpackage

// File: rtl/mpwm_regs.sv
// Register bank: staging copies written by the host port, and live copies
// that load from the staging copies on the counter wrap.
// Assumes wrap is a single-cycle strobe driven by the timebase.
module mpwm_regs
    import mpwm_pkg::*;
#(
    parameter int CH         = 4,
    parameter int W          = 16,
    parameter int DEF_PERIOD = 16,
    localparam int AW        = $clog2(2 * CH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          wrap,
    output logic [W-1:0]  act_period,
    output logic [CH*W-1:0] act_phase,
    output logic [CH*W-1:0] act_duty
);
    localparam logic [AW-1:0] A_PER = AW'(PERIOD_ADDR);

    logic [W-1:0]    stg_period;
    logic [CH*W-1:0] stg_phase;
    logic [CH*W-1:0] stg_duty;

    // Staging period: host writes land here at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)                         stg_period <= W'(DEF_PERIOD);
        else if (wr_en && wr_addr == A_PER) stg_period <= wr_data;
    end

    // Live period: loads the staged value only at the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)    act_period <= W'(DEF_PERIOD);
        else if (wrap) act_period <= stg_period;
    end

    for (genvar k = 0; k < CH; k++) begin : g_ch
        localparam logic [AW-1:0] A_PH = AW'(phase_addr(k));
        localparam logic [AW-1:0] A_DU = AW'(duty_addr(k));

        // Staging offset and duty of channel k.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg_phase[k*W +: W] <= '0;
                stg_duty[k*W +: W]  <= '0;
            end else if (wr_en) begin
                if (wr_addr == A_PH) stg_phase[k*W +: W] <= wr_data;
                if (wr_addr == A_DU) stg_duty[k*W +: W]  <= wr_data;
            end
        end

        // Live offset and duty of channel k, updated at the wrap.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_phase[k*W +: W] <= '0;
                act_duty[k*W +: W]  <= '0;
            end else if (wrap) begin
                act_phase[k*W +: W] <= stg_phase[k*W +: W];
                act_duty[k*W +: W]  <= stg_duty[k*W +: W];
            end
        end
    end
endmodule

// File: rtl/mpwm_timebase.sv
// Shared period counter: counts 0 .. eff_period-1, then restarts at 0.
// Assumes eff_period is never 0 (the top maps 0 to 1).
module mpwm_timebase #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] eff_period,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    // Wrap on the last count; >= also covers a shrinking period.
    always_comb wrap = (cnt >= eff_period - W'(1));

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (wrap) cnt <= '0;
        else           cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/mpwm_channel.sv
// One PWM channel: decides whether the current count lies inside the
// window [offset, offset+duty) modulo the period, and registers the result.
// Assumes cnt < eff_period and eff_period >= 1.
module mpwm_channel #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] eff_period,
    input  logic [W-1:0] phase,
    input  logic [W-1:0] duty,
    output logic         pwm_q
);
    logic [W-1:0] ph;
    logic [W-1:0] pos;
    logic         hit;

    // Position of the count inside this channel's shifted period.
    always_comb begin
        ph  = (phase >= eff_period) ? '0 : phase;
        pos = (cnt >= ph) ? (cnt - ph) : (cnt + (eff_period - ph));
        hit = (pos < duty);
    end

    // Output flop so that all channels switch on one edge.
    always_ff @(posedge clk) begin
        if (!rst_n) pwm_q <= 1'b0;
        else        pwm_q <= hit;
    end
endmodule

// File: rtl/mpwm_gen.sv
// Top: multi-phase PWM generator. One shared timebase and CH channels.
// Settings go through the staging/live register bank.
// Assumes a synchronous active-low reset and one clock domain.
module mpwm_gen #(
    parameter int CH         = 4,
    parameter int W          = 16,
    parameter int DEF_PERIOD = 16,
    localparam int AW        = $clog2(2 * CH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    output logic [CH-1:0] pwm_o
);
    logic [W-1:0]    act_period;
    logic [W-1:0]    eff_period;
    logic [CH*W-1:0] act_phase;
    logic [CH*W-1:0] act_duty;
    logic [W-1:0]    cnt;
    logic            wrap;

    // A period of zero acts as a period of one.
    always_comb eff_period = (act_period == '0) ? W'(1) : act_period;

    mpwm_regs #(.CH(CH), .W(W), .DEF_PERIOD(DEF_PERIOD)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wrap(wrap), .act_period(act_period),
        .act_phase(act_phase), .act_duty(act_duty)
    );

    mpwm_timebase #(.W(W)) u_tb (
        .clk(clk), .rst_n(rst_n), .eff_period(eff_period),
        .cnt(cnt), .wrap(wrap)
    );

    for (genvar k = 0; k < CH; k++) begin : g_chan
        mpwm_channel #(.W(W)) u_chan (
            .clk(clk), .rst_n(rst_n), .cnt(cnt), .eff_period(eff_period),
            .phase(act_phase[k*W +: W]), .duty(act_duty[k*W +: W]),
            .pwm_q(pwm_o[k])
        );
    end
endmodule

// File: rtl/mpwm_gen_chk.sv
// Checker for mpwm_gen. It watches the counter, the live settings and the
// outputs. It is attached to every mpwm_gen instance by the bind below.
module mpwm_gen_chk #(
    parameter int CH = 4,
    parameter int W  = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [W-1:0]    cnt,
    input logic [W-1:0]    eff_period,
    input logic [W-1:0]    act_period,
    input logic [CH*W-1:0] act_duty,
    input logic [CH-1:0]   pwm_o
);
    // R1: a cycle spent in reset leaves all outputs low.
    p_reset_low_r1: assert property (@(posedge clk)
        !rst_n |=> (pwm_o == '0));

    // R2: the counter stays below the effective period.
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < eff_period);

    // R2: a nonzero count is always the previous count plus one.
    p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> (cnt == $past(cnt) + W'(1)));

    // R5: the live period changes only when the counter sits at 0.
    p_period_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> $stable(act_period));

    for (genvar k = 0; k < CH; k++) begin : g_a
        // R4: zero duty gives a low output in the following cycle.
        p_duty_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(act_duty[k*W +: W]) == '0) |-> !pwm_o[k]);

        // R4: a duty at or above the period gives a high output.
        p_duty_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(act_duty[k*W +: W]) >= $past(eff_period)) |-> pwm_o[k]);
    end
endmodule

bind mpwm_gen mpwm_gen_chk #(.CH(CH), .W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .eff_period(eff_period),
    .act_period(act_period), .act_duty(act_duty), .pwm_o(pwm_o)
);

// File: tb/mpwm_gen_bench.sv
// Directed bench for mpwm_gen. A cycle-accurate model built from the
// requirements predicts every output; each task drives one scenario.
module mpwm_gen_bench;
    localparam int CH   = 4;
    localparam int W    = 16;
    localparam int DEFP = 16;
    localparam int AW   = $clog2(2 * CH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [CH-1:0] pwm_o;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    mpwm_gen #(.CH(CH), .W(W), .DEF_PERIOD(DEFP)) u_mpwm_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_o(pwm_o)
    );

    // Reference model, written from the requirements.
    int m_cnt, m_per, s_per;
    int m_ph[CH], m_du[CH], s_ph[CH], s_du[CH];
    logic [CH-1:0] m_pwm;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_per = DEFP; s_per = DEFP; m_pwm = '0;
            for (int k = 0; k < CH; k++) begin
                m_ph[k] = 0; m_du[k] = 0; s_ph[k] = 0; s_du[k] = 0;
            end
        end else begin
            int p;
            p = (m_per == 0) ? 1 : m_per;                 // R8
            for (int k = 0; k < CH; k++) begin
                int ph;
                ph = (m_ph[k] >= p) ? 0 : m_ph[k];        // R7
                m_pwm[k] = (((m_cnt - ph + p) % p) < m_du[k]); // R3
            end
            if (m_cnt >= p - 1) begin                     // R2, R5
                m_cnt = 0; m_per = s_per;
                for (int k = 0; k < CH; k++) begin
                    m_ph[k] = s_ph[k]; m_du[k] = s_du[k];
                end
            end else begin
                m_cnt = m_cnt + 1;
            end
            if (wr_en) begin                              // R6
                if (wr_addr == 0) s_per = wr_data;
                for (int k = 0; k < CH; k++) begin
                    if (wr_addr == AW'(2 * k + 1)) s_ph[k] = wr_data;
                    if (wr_addr == AW'(2 * k + 2)) s_du[k] = wr_data;
                end
            end
        end
    end

    // Compare outputs with the model at each falling edge for n cycles.
    task automatic run_cmp(input int n, input string tag);
        repeat (n) begin
            @(negedge clk);
            tests++;
            if (pwm_o !== m_pwm) begin
                fails++;
                $display("FAIL %s: pwm_o=%b expected %b (count %0d)",
                         tag, pwm_o, m_pwm, m_cnt);
            end
        end
    endtask

    // One-cycle host write, driven at the falling edge.
    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_count(input int c);
        while (m_cnt != c) @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        run_cmp(3, "R1");
        @(negedge clk); rst_n = 1'b1;
        tests++;
        if (pwm_o !== '0) begin
            fails++; $display("FAIL R1: pwm_o=%b expected 0", pwm_o);
        end
        run_cmp(2 * DEFP, "R1");
    endtask

    task automatic t_basic;
        wr(0, 10);
        wr(1, 0); wr(2, 3);
        wr(3, 2); wr(4, 4);
        wr(5, 5); wr(6, 1);
        wr(7, 7); wr(8, 6);
        run_cmp(60, "R2");
        run_cmp(20, "R9");
    endtask

    task automatic t_window;
        wr(1, 8); wr(2, 5);      // high at counts 8,9,0,1,2
        wr(3, 9); wr(4, 9);
        run_cmp(40, "R3");
    endtask

    task automatic t_extremes;
        wr(2, 0); wr(4, 10); wr(6, 16'hFFFF); wr(8, 9);
        run_cmp(25, "R4");
        wait_count(4);
        tests++;
        if (pwm_o[1] !== 1'b1 || pwm_o[0] !== 1'b0) begin
            fails++; $display("FAIL R4: pwm_o=%b expected x x 1 0 in low bits", pwm_o);
        end
    endtask

    task automatic t_shadow;
        wait_count(3);
        wr(2, 10);               // mid-period write
        run_cmp(15, "R5");
        wait_count(8);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(2); wr_data = W'(0); // accepted on the wrap edge
        @(negedge clk);
        wr_en = 1'b0;
        run_cmp(25, "R5");
    endtask

    task automatic t_addr;
        for (int a = 2 * CH + 1; a < (1 << AW); a++) wr(a, 16'h5A5A);
        run_cmp(25, "R6");
        wr(7, 3); wr(8, 2);
        run_cmp(25, "R6");
    endtask

    task automatic t_phase_big;
        wr(1, 12); wr(2, 3);
        wr(3, 10); wr(4, 2);
        run_cmp(30, "R7");
    endtask

    task automatic t_tiny;
        wr(0, 1); wr(2, 1); wr(4, 0);
        run_cmp(15, "R8");
        wr(0, 0);
        run_cmp(15, "R8");
        wr(0, 6);
        run_cmp(20, "R8");
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_window();
        t_extremes();
        t_shadow();
        t_addr();
        t_phase_big();
        t_tiny();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule